// File: doc/BRIEF.md
# Cache Maintenance and Test-Register Controller

This block controls a four-way set-associative on-chip cache model. It has two jobs. The first is to run whole-cache maintenance on request. A plain invalidate clears every valid bit and tells the external caches to flush. A write-back-and-invalidate clears the valid bits and sends two special bus cycles: a write-back request, then a flush request. Each command occupies the controller for a fixed number of cycles. The bus towards the outside is reduced to a one-cycle special-cycle strobe that carries a 2-bit code.

The second job is to give privileged software a path into the cache through three test registers:

- A data register that moves one doubleword.
- A state register that holds a tag, the valid bit of one way, the tree replacement bits of the set and the set's four valid bits.
- A control register. Writing it runs an operation on the way or line word that it selects.

An operation can move one doubleword between the data register and a four-word line buffer. It can also write the buffer, tag and valid bit into a chosen way, read a way back into the buffer and the state register, or drop every valid bit. Any test access is refused unless the requester is at privilege level zero. It is also refused while maintenance is running or starting.

Top module: `cache_tmc`

## Requirements
- R1: A maintenance request with `maint_kind`=0 (invalidate) is taken when the controller is idle. It clears every valid bit at the accepting edge. `maint_busy` then stays high for 4 cycles and `maint_done` is high only in the 4th. Exactly one strobe is sent, in busy cycle 2, with code 2'b01 (flush external caches).
- R2: A maintenance request with `maint_kind`=1 (write back then invalidate) clears every valid bit. It keeps `maint_busy` high for 5 cycles, with `maint_done` only in the 5th. It sends a strobe with code 2'b10 (write back) in busy cycle 2 and one with code 2'b01 in busy cycle 3.
- R3: A maintenance request made while the controller is busy is ignored. The running command keeps its length and its strobe codes.
- R4: The test registers sit at `tr_addr` 0 (data), 1 (state) and 2 (control); address 3 reads zero and ignores writes. The control fields are: operation in bits [1:0], entry in bits [3:2], direction in bit 4 and set index in bits [8+SET_W-1:8]. Writing control with operation 01 writes way `entry` of the set. The way takes the line buffer as its data, and the tag and way-valid bit from the state register.
- R5: Operation 10 reads way `entry` of the set. The line goes into the line buffer. The state register takes the tag in bits [TAG_W-1:0], the way's valid bit in bit 16, the set's replacement bits in [19:17] and the set's valid vector in [23:20], where bit 20+w is way w.
- R6: Operation 00 moves line-buffer word `entry`. With direction 1 it copies the data register into that word. With direction 0 it copies that word into the data register.
- R7: Operation 11 clears all valid bits in one cycle. Tags, line data and replacement bits are kept.
- R8: Each way write through the test interface updates the set's 3 replacement bits so that they point away from the written way. Bit 0 is set to the inverse of way bit 1. Then bit 1 (for ways 0 and 1) or bit 2 (for ways 2 and 3) is set to the inverse of way bit 0. The other bit is kept.
- R9: A test request with `tr_priv` not zero is rejected. `tr_fault` is high in the following cycle, and no register or cache state changes. While `tr_priv` is not zero, `tr_rdata` reads zero.
- R10: A test request is rejected with a fault pulse and has no effect if it comes in a cycle where maintenance is busy or is being accepted.
- R11: After reset the controller is idle with no strobe and no fault. All registers read zero. Every valid bit, tag and replacement bit is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| maint_req | input | 1 | Maintenance command request |
| maint_kind | input | 1 | 0 invalidate, 1 write back then invalidate |
| maint_busy | output | 1 | Maintenance command in progress |
| maint_done | output | 1 | Last cycle of a maintenance command |
| spc_strobe | output | 1 | Special bus cycle strobe |
| spc_code | output | 2 | Special cycle type: 01 flush, 10 write back |
| tr_req | input | 1 | Test-register access request |
| tr_we | input | 1 | Access is a write |
| tr_addr | input | 2 | Test register select |
| tr_wdata | input | 32 | Write data |
| tr_priv | input | 2 | Requester privilege level |
| tr_rdata | output | 32 | Selected register contents (zero when privilege is not zero) |
| tr_fault | output | 1 | Rejected access, one cycle after the request |

## Verification
A test-register write can land in the same cycle as a maintenance request, or during a command that is already running. Both can change shared cache state, so the controller gives priority to maintenance. The bench provokes both cases: it raises `maint_req` and a data-register write on the same clock edge, and it issues a write in the first busy cycle. In each case it expects a fault pulse on the next cycle and the command's normal busy length. Once the controller is idle again, it reads the data register back unchanged.

// File: rtl/cache_tmc_pkg.sv
package cache_tmc_pkg;

    localparam int DW        = 32;
    localparam int WAYS      = 4;
    localparam int WORDS     = 4;
    localparam int INV_LAT   = 4;
    localparam int WBINV_LAT = 5;

    // control register field positions
    localparam int CF_OP_LO  = 0;
    localparam int CF_ENT_LO = 2;
    localparam int CF_DIR    = 4;
    localparam int CF_SET_LO = 8;

    // state register field positions
    localparam int SF_WV      = 16;
    localparam int SF_PLRU_LO = 17;
    localparam int SF_VEC_LO  = 20;

    typedef logic [WORDS-1:0][DW-1:0] line_t;

    typedef enum logic [1:0] {
        OP_FILLBUF = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b10,
        OP_INVALL  = 2'b11
    } tr_op_e;

    typedef enum logic [1:0] {
        RG_DATA  = 2'b00,
        RG_STATE = 2'b01,
        RG_CTRL  = 2'b10,
        RG_NONE  = 2'b11
    } tr_reg_e;

    typedef enum logic {
        MK_INV   = 1'b0,
        MK_WBINV = 1'b1
    } maint_e;

    typedef enum logic [1:0] {
        SC_NONE  = 2'b00,
        SC_FLUSH = 2'b01,
        SC_WBACK = 2'b10
    } spc_e;

    function automatic logic [2:0] maint_lat(maint_e k);
        return (k == MK_WBINV) ? 3'(WBINV_LAT) : 3'(INV_LAT);
    endfunction

    // tree bits point at the next victim; touching a way points them away
    function automatic logic [2:0] plru_touch(logic [2:0] p, logic [1:0] w);
        logic [2:0] n;
        n    = p;
        n[0] = ~w[1];
        if (w[1]) n[2] = ~w[0];
        else      n[1] = ~w[0];
        return n;
    endfunction

    function automatic logic [1:0] plru_victim(logic [2:0] p);
        return p[0] ? {1'b1, p[2]} : {1'b0, p[1]};
    endfunction

endpackage

// File: rtl/cache_tmc_seq.sv
module cache_tmc_seq
    import cache_tmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       maint_req,
    input  logic       maint_kind,
    output logic       busy,
    output logic       start,
    output logic       done,
    output maint_e     cur_kind,
    output logic       spc_strobe,
    output logic [1:0] spc_code
);

    logic [2:0] step_q;
    maint_e     kind_q;
    logic       busy_q;
    logic [2:0] lat;
    spc_e       code;

    assign start = maint_req && !busy_q;
    assign lat   = maint_lat(kind_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            step_q <= '0;
            kind_q <= MK_INV;
        end else if (start) begin
            busy_q <= 1'b1;
            step_q <= 3'd1;
            kind_q <= maint_e'(maint_kind);
        end else if (busy_q) begin
            if (step_q == lat) begin
                busy_q <= 1'b0;
                step_q <= '0;
            end else begin
                step_q <= step_q + 3'd1;
            end
        end
    end

    always_comb begin
        code = SC_NONE;
        if (busy_q && step_q == 3'd2)
            code = (kind_q == MK_WBINV) ? SC_WBACK : SC_FLUSH;
        else if (busy_q && kind_q == MK_WBINV && step_q == 3'd3)
            code = SC_FLUSH;
    end

    assign busy       = busy_q;
    assign done       = busy_q && (step_q == lat);
    assign cur_kind   = kind_q;
    assign spc_code   = code;
    assign spc_strobe = (code != SC_NONE);

    AST_SPC_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        spc_strobe |-> busy);                                                  // R1
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);                                                       // R2
    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && $stable(cur_kind)));                      // R3
    AST_WBACK_FIRST: assert property (@(posedge clk) disable iff (rst)
        (spc_strobe && spc_code == SC_WBACK) |=> (spc_strobe && spc_code == SC_FLUSH)); // R2

endmodule

// File: rtl/cache_tmc_store.sv
module cache_tmc_store
    import cache_tmc_pkg::*;
#(
    parameter int SET_W = 3,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [1:0]       wr_way,
    input  line_t            wr_line,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_vbit,
    input  logic [SET_W-1:0] rd_set,
    input  logic [1:0]       rd_way,
    output line_t            rd_line,
    output logic [TAG_W-1:0] rd_tag,
    output logic [WAYS-1:0]  rd_vvec,
    output logic [2:0]       rd_plru
);

    localparam int SETS = 1 << SET_W;

    logic [WAYS-1:0]  vld_q  [SETS];
    logic [2:0]       plru_q [SETS];
    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    line_t            line_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]  <= '0;
                plru_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]  <= '0;
                    line_q[s][w] <= '0;
                end
            end
        end else begin
            if (clr_all) begin
                for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
            end
            if (wr_en) begin
                vld_q[wr_set][wr_way]  <= wr_vbit;
                tag_q[wr_set][wr_way]  <= wr_tag;
                line_q[wr_set][wr_way] <= wr_line;
                plru_q[wr_set]         <= plru_touch(plru_q[wr_set], wr_way);
            end
        end
    end

    assign rd_line = line_q[rd_set][rd_way];
    assign rd_tag  = tag_q[rd_set][rd_way];
    assign rd_vvec = vld_q[rd_set];
    assign rd_plru = plru_q[rd_set];

    // assertion support
    logic             any_valid;
    logic [SET_W-1:0] last_set;
    logic [1:0]       last_way;

    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < SETS; s++) any_valid = any_valid | (|vld_q[s]);
    end

    always_ff @(posedge clk) begin
        last_set <= wr_set;
        last_way <= wr_way;
    end

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (clr_all && !wr_en) |=> !any_valid);                                   // R7
    AST_PLRU_AWAY: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (plru_victim(plru_q[last_set]) != last_way));                // R8
    AST_NO_CLASH: assert property (@(posedge clk) disable iff (rst)
        !(clr_all && wr_en));                                                  // R10

endmodule

// File: rtl/cache_tmc_treg.sv
module cache_tmc_treg
    import cache_tmc_pkg::*;
#(
    parameter int SET_W = 3,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tr_req,
    input  logic             tr_we,
    input  logic [1:0]       tr_addr,
    input  logic [DW-1:0]    tr_wdata,
    input  logic [1:0]       tr_priv,
    input  logic             maint_block,
    output logic [DW-1:0]    tr_rdata,
    output logic             tr_fault,
    output logic             wr_en,
    output logic [SET_W-1:0] wr_set,
    output logic [1:0]       wr_way,
    output line_t            wr_line,
    output logic [TAG_W-1:0] wr_tag,
    output logic             wr_vbit,
    output logic             clr_all,
    output logic [SET_W-1:0] rd_set,
    output logic [1:0]       rd_way,
    input  line_t            rd_line,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic [WAYS-1:0]  rd_vvec,
    input  logic [2:0]       rd_plru
);

    typedef struct packed {
        logic [WAYS-1:0]  vec;
        logic [2:0]       plru;
        logic             wv;
        logic [TAG_W-1:0] tag;
    } state_t;

    typedef struct packed {
        logic [SET_W-1:0] set;
        logic             dir;
        logic [1:0]       ent;
        tr_op_e           op;
    } ctrl_t;

    logic [DW-1:0] data_q;
    state_t        state_q;
    ctrl_t         ctrl_q;
    line_t         fill_q;
    logic          fault_q;

    logic   reject, accept, ctl_wr;
    ctrl_t  wc;
    tr_reg_e reg_sel;

    assign reg_sel = tr_reg_e'(tr_addr);
    assign reject  = tr_req && ((tr_priv != 2'd0) || maint_block);
    assign accept  = tr_req && !reject;
    assign ctl_wr  = accept && tr_we && (reg_sel == RG_CTRL);

    assign wc.op  = tr_op_e'(tr_wdata[CF_OP_LO +: 2]);
    assign wc.ent = tr_wdata[CF_ENT_LO +: 2];
    assign wc.dir = tr_wdata[CF_DIR];
    assign wc.set = tr_wdata[CF_SET_LO +: SET_W];

    // cache array side
    assign rd_set  = wc.set;
    assign rd_way  = wc.ent;
    assign wr_set  = wc.set;
    assign wr_way  = wc.ent;
    assign wr_en   = ctl_wr && (wc.op == OP_WRITE);
    assign clr_all = ctl_wr && (wc.op == OP_INVALL);
    assign wr_line = fill_q;
    assign wr_tag  = state_q.tag;
    assign wr_vbit = state_q.wv;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            state_q <= '0;
            ctrl_q  <= '0;
            fill_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            fault_q <= reject;
            if (accept && tr_we) begin
                case (reg_sel)
                    RG_DATA:  data_q <= tr_wdata;
                    RG_STATE: begin
                        state_q.tag  <= tr_wdata[TAG_W-1:0];
                        state_q.wv   <= tr_wdata[SF_WV];
                        state_q.plru <= tr_wdata[SF_PLRU_LO +: 3];
                        state_q.vec  <= tr_wdata[SF_VEC_LO +: WAYS];
                    end
                    RG_CTRL: begin
                        ctrl_q <= wc;
                        case (wc.op)
                            OP_FILLBUF: begin
                                if (wc.dir) fill_q[wc.ent] <= data_q;
                                else        data_q <= fill_q[wc.ent];
                            end
                            OP_READ: begin
                                fill_q       <= rd_line;
                                state_q.tag  <= rd_tag;
                                state_q.wv   <= rd_vvec[wc.ent];
                                state_q.plru <= rd_plru;
                                state_q.vec  <= rd_vvec;
                            end
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    logic [DW-1:0] state_word, ctrl_word, sel_word;

    always_comb begin
        state_word = '0;
        state_word[TAG_W-1:0]            = state_q.tag;
        state_word[SF_WV]                = state_q.wv;
        state_word[SF_PLRU_LO +: 3]      = state_q.plru;
        state_word[SF_VEC_LO +: WAYS]    = state_q.vec;
        ctrl_word = '0;
        ctrl_word[CF_OP_LO +: 2]         = ctrl_q.op;
        ctrl_word[CF_ENT_LO +: 2]        = ctrl_q.ent;
        ctrl_word[CF_DIR]                = ctrl_q.dir;
        ctrl_word[CF_SET_LO +: SET_W]    = ctrl_q.set;
        case (reg_sel)
            RG_DATA:  sel_word = data_q;
            RG_STATE: sel_word = state_word;
            RG_CTRL:  sel_word = ctrl_word;
            default:  sel_word = '0;
        endcase
    end

    assign tr_rdata = (tr_priv == 2'd0) ? sel_word : '0;
    assign tr_fault = fault_q;

    AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        tr_fault |-> (data_q == $past(data_q) && state_q == $past(state_q)
                      && ctrl_q == $past(ctrl_q) && fill_q == $past(fill_q))); // R9
    AST_PRIV_FAULT: assert property (@(posedge clk) disable iff (rst)
        (tr_req && tr_priv != 2'd0) |=> tr_fault);                             // R9
    AST_MAINT_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
        (tr_req && maint_block) |=> tr_fault);                                 // R10

endmodule

// File: rtl/cache_tmc.sv
module cache_tmc
    import cache_tmc_pkg::*;
#(
    parameter int SET_W = 3,
    parameter int TAG_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        maint_req,
    input  logic        maint_kind,
    output logic        maint_busy,
    output logic        maint_done,
    output logic        spc_strobe,
    output logic [1:0]  spc_code,
    input  logic        tr_req,
    input  logic        tr_we,
    input  logic [1:0]  tr_addr,
    input  logic [31:0] tr_wdata,
    input  logic [1:0]  tr_priv,
    output logic [31:0] tr_rdata,
    output logic        tr_fault
);

    logic             start, busy, tr_clr, clr_all;
    maint_e           cur_kind;
    logic             wr_en, wr_vbit;
    logic [SET_W-1:0] wr_set, rd_set;
    logic [1:0]       wr_way, rd_way;
    line_t            wr_line, rd_line;
    logic [TAG_W-1:0] wr_tag, rd_tag;
    logic [WAYS-1:0]  rd_vvec;
    logic [2:0]       rd_plru;

    cache_tmc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .maint_req  (maint_req),
        .maint_kind (maint_kind),
        .busy       (busy),
        .start      (start),
        .done       (maint_done),
        .cur_kind   (cur_kind),
        .spc_strobe (spc_strobe),
        .spc_code   (spc_code)
    );

    cache_tmc_treg #(.SET_W(SET_W), .TAG_W(TAG_W)) u_treg (
        .clk         (clk),
        .rst         (rst),
        .tr_req      (tr_req),
        .tr_we       (tr_we),
        .tr_addr     (tr_addr),
        .tr_wdata    (tr_wdata),
        .tr_priv     (tr_priv),
        .maint_block (busy || start),
        .tr_rdata    (tr_rdata),
        .tr_fault    (tr_fault),
        .wr_en       (wr_en),
        .wr_set      (wr_set),
        .wr_way      (wr_way),
        .wr_line     (wr_line),
        .wr_tag      (wr_tag),
        .wr_vbit     (wr_vbit),
        .clr_all     (tr_clr),
        .rd_set      (rd_set),
        .rd_way      (rd_way),
        .rd_line     (rd_line),
        .rd_tag      (rd_tag),
        .rd_vvec     (rd_vvec),
        .rd_plru     (rd_plru)
    );

    assign clr_all = start || tr_clr;

    cache_tmc_store #(.SET_W(SET_W), .TAG_W(TAG_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clr_all (clr_all),
        .wr_en   (wr_en),
        .wr_set  (wr_set),
        .wr_way  (wr_way),
        .wr_line (wr_line),
        .wr_tag  (wr_tag),
        .wr_vbit (wr_vbit),
        .rd_set  (rd_set),
        .rd_way  (rd_way),
        .rd_line (rd_line),
        .rd_tag  (rd_tag),
        .rd_vvec (rd_vvec),
        .rd_plru (rd_plru)
    );

    assign maint_busy = busy;

    // busy-length counter used to check command latency
    logic [2:0] busy_len;
    always_ff @(posedge clk) begin
        if (rst)        busy_len <= '0;
        else if (start) busy_len <= 3'd1;
        else if (busy)  busy_len <= busy_len + 3'd1;
        else            busy_len <= '0;
    end

    AST_MAINT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        maint_done |-> (busy_len == ((cur_kind == MK_WBINV) ? 3'(WBINV_LAT) : 3'(INV_LAT)))); // R1
    AST_STROBE_CODE: assert property (@(posedge clk) disable iff (rst)
        spc_strobe |-> (spc_code == SC_FLUSH || spc_code == SC_WBACK));        // R2

endmodule

// File: tb/cache_tmc_test.sv
module cache_tmc_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        maint_req, maint_kind;
    logic        maint_busy, maint_done, spc_strobe;
    logic [1:0]  spc_code;
    logic        tr_req, tr_we;
    logic [1:0]  tr_addr, tr_priv;
    logic [31:0] tr_wdata, tr_rdata;
    logic        tr_fault;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    cache_tmc uut (
        .clk(clk), .rst(rst),
        .maint_req(maint_req), .maint_kind(maint_kind),
        .maint_busy(maint_busy), .maint_done(maint_done),
        .spc_strobe(spc_strobe), .spc_code(spc_code),
        .tr_req(tr_req), .tr_we(tr_we), .tr_addr(tr_addr),
        .tr_wdata(tr_wdata), .tr_priv(tr_priv),
        .tr_rdata(tr_rdata), .tr_fault(tr_fault)
    );

    typedef struct packed {
        logic [1:0]  addr;
        logic [31:0] wdata;
        logic [1:0]  chk;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 27;
    // addr/chk: 0 data, 1 state, 2 control
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h1111_0000, 2'd0, 32'h1111_0000},
        '{2'd2, 32'h0000_0010, 2'd2, 32'h0000_0010},
        '{2'd0, 32'h1111_0001, 2'd0, 32'h1111_0001},
        '{2'd2, 32'h0000_0014, 2'd2, 32'h0000_0014},
        '{2'd0, 32'h1111_0002, 2'd0, 32'h1111_0002},
        '{2'd2, 32'h0000_0018, 2'd2, 32'h0000_0018},
        '{2'd0, 32'h1111_0003, 2'd0, 32'h1111_0003},
        '{2'd2, 32'h0000_001C, 2'd2, 32'h0000_001C},
        '{2'd1, 32'h0001_005A, 2'd1, 32'h0001_005A},
        '{2'd2, 32'h0000_0309, 2'd2, 32'h0000_0309},
        '{2'd0, 32'h0000_0000, 2'd0, 32'h0000_0000},
        '{2'd2, 32'h0000_0004, 2'd0, 32'h1111_0001},
        '{2'd2, 32'h0000_030A, 2'd1, 32'h0049_005A},
        '{2'd0, 32'h0000_DEAD, 2'd0, 32'h0000_DEAD},
        '{2'd2, 32'h0000_001C, 2'd0, 32'h0000_DEAD},
        '{2'd2, 32'h0000_030A, 2'd1, 32'h0049_005A},
        '{2'd2, 32'h0000_000C, 2'd0, 32'h1111_0003},
        '{2'd1, 32'h0001_0033, 2'd1, 32'h0001_0033},
        '{2'd2, 32'h0000_0301, 2'd2, 32'h0000_0301},
        '{2'd2, 32'h0000_0302, 2'd1, 32'h005F_0033},
        '{2'd2, 32'h0000_0306, 2'd1, 32'h005E_0000},
        '{2'd2, 32'h0000_0003, 2'd2, 32'h0000_0003},
        '{2'd2, 32'h0000_030A, 2'd1, 32'h000E_005A},
        '{2'd2, 32'h0000_0008, 2'd0, 32'h1111_0002},
        '{2'd1, 32'h0001_00C3, 2'd1, 32'h0001_00C3},
        '{2'd2, 32'h0000_050D, 2'd2, 32'h0000_050D},
        '{2'd2, 32'h0000_050E, 2'd1, 32'h0081_00C3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // one-cycle test access; returns the fault seen the cycle after
    task automatic tr_access(input logic we, input logic [1:0] addr,
                             input logic [31:0] data, input logic [1:0] priv,
                             output logic fault);
        @(negedge clk);
        tr_req = 1'b1; tr_we = we; tr_addr = addr; tr_wdata = data; tr_priv = priv;
        @(negedge clk);
        fault  = tr_fault;
        tr_req = 1'b0; tr_we = 1'b0; tr_priv = 2'd0;
    endtask

    task automatic rd_reg(input logic [1:0] addr, output logic [31:0] val);
        tr_addr = addr; tr_priv = 2'd0;
        #1;
        val = tr_rdata;
    endtask

    // run one command, checking each busy cycle; ext_k injects a second request
    task automatic run_maint(input logic kind, input int ext_k, input string req);
        int lat;
        lat = kind ? 5 : 4;
        @(negedge clk);
        maint_req = 1'b1; maint_kind = kind;
        @(negedge clk);
        maint_req = 1'b0;
        for (int k = 1; k <= lat + 1; k++) begin
            logic [1:0] ec;
            ec = 2'b00;
            if (k == 2) ec = kind ? 2'b10 : 2'b01;
            if (k == 3 && kind) ec = 2'b01;
            chk({req, " busy"},   32'(maint_busy), 32'(k <= lat));
            chk({req, " done"},   32'(maint_done), 32'(k == lat));
            chk({req, " strobe"}, 32'(spc_strobe), 32'(ec != 2'b00));
            chk({req, " code"},   32'(spc_strobe ? spc_code : 2'b00), 32'(ec));
            if (ext_k != 0 && k >= ext_k && k < lat) begin
                maint_req = 1'b1; maint_kind = ~kind;
            end else begin
                maint_req = 1'b0;
            end
            @(negedge clk);
        end
        maint_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic        f;
        rst = 1'b1; maint_req = 1'b0; maint_kind = 1'b0;
        tr_req = 1'b0; tr_we = 1'b0; tr_addr = 2'd0; tr_wdata = '0; tr_priv = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11 busy", 32'(maint_busy), 32'd0);
        chk("R11 strobe", 32'(spc_strobe), 32'd0);
        chk("R11 fault", 32'(tr_fault), 32'd0);
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), v);
            chk("R11 register", v, 32'd0);
        end

        // R4 R5 R6 R7 R8 R11: vector table
        for (int i = 0; i < NV; i++) begin
            tr_access(1'b1, VECS[i].addr, VECS[i].wdata, 2'd0, f);
            chk("R4 no fault", 32'(f), 32'd0);
            rd_reg(VECS[i].chk, v);
            chk($sformatf("R4-R8 vector %0d", i), v, VECS[i].exp);
        end

        // R4 reserved address ignored
        tr_access(1'b1, 2'd3, 32'hFFFF_FFFF, 2'd0, f);
        rd_reg(2'd3, v);
        chk("R4 reserved reads zero", v, 32'd0);

        // R9 privilege rejection
        tr_access(1'b1, 2'd0, 32'h600D_0009, 2'd0, f);
        tr_access(1'b1, 2'd0, 32'h0000_0BAD, 2'd3, f);
        chk("R9 fault", 32'(f), 32'd1);
        tr_addr = 2'd0; tr_priv = 2'd1; #1;
        chk("R9 rdata zero", tr_rdata, 32'd0);
        rd_reg(2'd0, v);
        chk("R9 data kept", v, 32'h600D_0009);
        tr_access(1'b1, 2'd2, 32'h0000_0003, 2'd2, f);
        tr_access(1'b1, 2'd2, 32'h0000_050E, 2'd0, f);
        rd_reg(2'd1, v);
        chk("R9 cache kept", v, 32'h0081_00C3);

        // R10 collision in the accepting cycle
        @(negedge clk);
        maint_req = 1'b1; maint_kind = 1'b0;
        tr_req = 1'b1; tr_we = 1'b1; tr_addr = 2'd0; tr_wdata = 32'h0000_0777;
        @(negedge clk);
        maint_req = 1'b0; tr_req = 1'b0;
        chk("R10 fault on start", 32'(tr_fault), 32'd1);
        chk("R10 maintenance runs", 32'(maint_busy), 32'd1);
        // R10 access during busy cycle 1
        tr_req = 1'b1;
        @(negedge clk);
        tr_req = 1'b0;
        chk("R10 fault while busy", 32'(tr_fault), 32'd1);
        repeat (4) @(negedge clk);
        rd_reg(2'd0, v);
        chk("R10 data kept", v, 32'h600D_0009);

        // R1 invalidate
        tr_access(1'b1, 2'd1, 32'h0001_00C3, 2'd0, f);
        tr_access(1'b1, 2'd2, 32'h0000_050D, 2'd0, f);
        run_maint(1'b0, 0, "R1");
        tr_access(1'b1, 2'd2, 32'h0000_050E, 2'd0, f);
        rd_reg(2'd1, v);
        chk("R1 valid cleared", v, 32'h0000_00C3);

        // R2 write back then invalidate
        tr_access(1'b1, 2'd2, 32'h0000_050D, 2'd0, f);
        run_maint(1'b1, 0, "R2");
        tr_access(1'b1, 2'd2, 32'h0000_050E, 2'd0, f);
        rd_reg(2'd1, v);
        chk("R2 valid cleared", v, 32'h0000_00C3);

        // R3 requests while busy ignored
        run_maint(1'b0, 2, "R3");
        run_maint(1'b1, 2, "R3");

        finish_run();
    end

endmodule